// File: doc/BRIEF.md
# Two-Wire Byte Memory Slave with Zero-Delay Writes

This block is the slave side of a two-wire serial bus in front of an 8,192 x 8 byte memory that takes each write at bus speed, so there is never a busy period. The system clock oversamples the bus clock and data lines. From them the block recognises bus start and stop conditions, shifts bytes most significant bit first, and pulls the shared data line low through an output-enable pin. The pad itself is open-drain and sits outside the block.

A transaction opens with a device byte. If that byte selects this slave, the master either loads a two-byte memory address and then streams data bytes into the array, or streams bytes out from the address the slave currently holds. That address stays latched between transactions. A master performs a random read by sending a write header and the two address bytes, then a repeated start followed by a read header. When a write-protect input is high, the top quarter of the array becomes read-only.

Top module: `twi_fram_slave`

## Requirements
- R1: A falling data line while the clock is high is a START, and a rising data line while the clock is high is a STOP. Either condition abandons any operation in progress. A START always re-arms reception of a device byte, and a STOP releases the data line and leaves the slave idle.
- R2: The device byte is sent most significant bit first. Bits 7..4 must be 1010b, bits 3..1 must equal the three select straps, and bit 0 is the direction (1 = read, 0 = write). The slave pulls the ninth clock low only when type and select both match. On a mismatch it never drives the line again until the next START.
- R3: After a write header, the first byte carries the high address and the second the low address. Only the low 13 bits are kept, so bits 7..5 of the high byte have no effect.
- R4: A data byte is stored in the array on the clock edge that delivers its 8th bit, which comes before the acknowledge slot. A START or STOP that arrives before the 8th bit leaves memory unchanged.
- R5: The held address advances by one after every transferred byte, with no limit on burst length, and wraps from 1FFFh to 0000h.
- R6: While write-protect is high, a data byte aimed at 1800h..1FFFh is not acknowledged, does not change memory and does not advance the address. While write-protect is low, every address can be written.
- R7: A read header returns bytes starting at the held address, most significant bit first, beginning on the clock fall after the header's acknowledge. Output continues for as long as the master acknowledges. A master NACK ends the read, and the line stays released until the next START.
- R8: A repeated START after the two address bytes of a write header abandons the write but keeps the loaded address, so the read header that follows reads from that address.
- R9: Reset clears the held address to 0000h and releases the data line. Array contents survive reset. The address persists from one transaction to the next.
- R10: `sda_oe` = 1 pulls the bus data line low and `sda_oe` = 0 releases it. The slave changes `sda_oe` only while the clock is low and samples data only on clock rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the bus clock rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad (wired value) |
| sda_oe | output | 1 | 1 = pull the data line low, 0 = release it |
| sel_i | input | 3 | Device select straps compared with device byte bits 3..1 |
| wp_i | input | 1 | Write protect for the top quarter of the array |

## Verification
The bound checker watches four things on every cycle: the output enable never moves while the synchronised clock stays high, a STOP always leaves the line released, array writes only happen on a clock-rise event and never inside the protected quarter while protect is high, and each stored byte advances the address by exactly one. Whether a byte is acknowledged, what data is returned, how the address behaves across a repeated START or a device reset, wrap-around, and whether a frame that is abandoned or wrongly addressed leaves memory unchanged can only be seen in the bench's transaction scenarios. There, a behavioural model predicts the line drive for every bit slot and the bytes read back.

// File: rtl/twi_fram_pkg.sv
package twi_fram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,      // not selected, bus ignored until START
    ST_RX,        // shifting in a byte
    ST_SACK_WAIT, // byte complete, waiting for fall to drive ack
    ST_SACK,      // ack slot in progress
    ST_TX,        // shifting out a byte
    ST_MACK,      // waiting for master ack sample
    ST_MACK_END   // master acked, waiting for fall to load next byte
  } fsm_st_t;

  typedef enum logic [1:0] {
    BY_DEV,
    BY_AHI,
    BY_ALO,
    BY_DATA
  } byte_kind_t;

  localparam logic [3:0] DEV_TYPE = 4'b1010;

endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_p;
  logic [STAGES-1:0] sda_p;
  logic              scl_d;
  logic              sda_d;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_p <= '1;
          sda_p <= '1;
        end else begin
          scl_p <= scl_i;
          sda_p <= sda_i;
        end
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_p <= '1;
          sda_p <= '1;
        end else begin
          scl_p <= {scl_p[STAGES-2:0], scl_i};
          sda_p <= {sda_p[STAGES-2:0], sda_i};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_p[STAGES-1];
      sda_d <= sda_p[STAGES-1];
    end
  end

  assign scl_s     = scl_p[STAGES-1];
  assign sda_s     = sda_p[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/twi_fram_array.sv
module twi_fram_array #(
  parameter int AW = 13,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [0:DEPTH-1];

  // single write port, registered read port: maps onto block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/twi_proto_fsm.sv
module twi_proto_fsm
  import twi_fram_pkg::*;
#(
  parameter int AW   = 13,
  parameter int DW   = 8,
  parameter int SELW = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            scl_rise,
  input  logic            scl_fall,
  input  logic            start_det,
  input  logic            stop_det,
  input  logic            sda_s,
  input  logic [SELW-1:0] sel,
  input  logic            wp,
  input  logic [DW-1:0]   rd_data,
  output logic [AW-1:0]   addr,
  output logic            we,
  output logic [DW-1:0]   wdata,
  output logic            sda_oe
);

  localparam int BCW = $clog2(DW);
  localparam int HIW = AW - DW;

  fsm_st_t    st_q;
  byte_kind_t kind_q;
  logic [DW-1:0]  sh_q;
  logic [BCW-1:0] bit_q;
  logic [HIW-1:0] hi_q;
  logic           rd_q;
  logic           ack_q;

  logic [DW-1:0] byte_in;
  logic          last_bit;
  logic          prot;
  logic          dev_hit;

  assign byte_in  = {sh_q[DW-2:0], sda_s};
  assign last_bit = (bit_q == BCW'(DW-1));
  assign prot     = wp && (addr[AW-1:AW-2] == 2'b11);
  assign dev_hit  = (byte_in[DW-1:DW-4] == DEV_TYPE) && (byte_in[SELW:1] == sel);

  assign we    = (st_q == ST_RX) && scl_rise && last_bit && (kind_q == BY_DATA) && !prot;
  assign wdata = byte_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      kind_q <= BY_DEV;
      sh_q   <= '0;
      bit_q  <= '0;
      hi_q   <= '0;
      rd_q   <= 1'b0;
      ack_q  <= 1'b0;
      addr   <= '0;
      sda_oe <= 1'b0;
    end else if (start_det) begin
      st_q   <= ST_RX;
      kind_q <= BY_DEV;
      bit_q  <= '0;
      sda_oe <= 1'b0;
    end else if (stop_det) begin
      st_q   <= ST_IDLE;
      sda_oe <= 1'b0;
    end else begin
      case (st_q)
        ST_RX: begin
          if (scl_rise) begin
            sh_q  <= byte_in;
            bit_q <= bit_q + 1'b1;
            if (last_bit) begin
              bit_q <= '0;
              st_q  <= ST_SACK_WAIT;
              ack_q <= 1'b1;
              case (kind_q)
                BY_DEV: begin
                  rd_q <= byte_in[0];
                  if (!dev_hit) st_q <= ST_IDLE;
                end
                BY_AHI: hi_q <= byte_in[HIW-1:0];
                BY_ALO: addr <= {hi_q, byte_in};
                default: begin
                  if (prot) ack_q <= 1'b0;
                  else      addr  <= addr + 1'b1;
                end
              endcase
            end
          end
        end
        ST_SACK_WAIT: begin
          if (scl_fall) begin
            sda_oe <= ack_q;
            st_q   <= ST_SACK;
          end
        end
        ST_SACK: begin
          if (scl_fall) begin
            sda_oe <= 1'b0;
            bit_q  <= '0;
            if (!ack_q) begin
              st_q <= ST_IDLE;
            end else begin
              case (kind_q)
                BY_DEV: begin
                  if (rd_q) begin
                    st_q   <= ST_TX;
                    sh_q   <= rd_data;
                    sda_oe <= ~rd_data[DW-1];
                    addr   <= addr + 1'b1;
                  end else begin
                    st_q   <= ST_RX;
                    kind_q <= BY_AHI;
                  end
                end
                BY_AHI: begin
                  st_q   <= ST_RX;
                  kind_q <= BY_ALO;
                end
                default: begin
                  st_q   <= ST_RX;
                  kind_q <= BY_DATA;
                end
              endcase
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (last_bit) begin
              sda_oe <= 1'b0;
              st_q   <= ST_MACK;
            end else begin
              bit_q  <= bit_q + 1'b1;
              sda_oe <= ~sh_q[DW-2];
              sh_q   <= sh_q << 1;
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) st_q <= sda_s ? ST_IDLE : ST_MACK_END;
        end
        ST_MACK_END: begin
          if (scl_fall) begin
            st_q   <= ST_TX;
            bit_q  <= '0;
            sh_q   <= rd_data;
            sda_oe <= ~rd_data[DW-1];
            addr   <= addr + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/twi_fram_slave.sv
module twi_fram_slave
  import twi_fram_pkg::*;
#(
  parameter int AW          = 13,
  parameter int DW          = 8,
  parameter int SELW        = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            scl_i,
  input  logic            sda_i,
  output logic            sda_oe,
  input  logic [SELW-1:0] sel_i,
  input  logic            wp_i
);

  logic          scl_s;
  logic          sda_s;
  logic          scl_rise;
  logic          scl_fall;
  logic          start_det;
  logic          stop_det;
  logic [AW-1:0] cur_addr;
  logic          mem_we;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata;

  twi_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk       (clk),
    .rst       (rst),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  twi_proto_fsm #(.AW(AW), .DW(DW), .SELW(SELW)) fsm_i (
    .clk       (clk),
    .rst       (rst),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_s     (sda_s),
    .sel       (sel_i),
    .wp        (wp_i),
    .rd_data   (mem_rdata),
    .addr      (cur_addr),
    .we        (mem_we),
    .wdata     (mem_wdata),
    .sda_oe    (sda_oe)
  );

  twi_fram_array #(.AW(AW), .DW(DW)) array_i (
    .clk   (clk),
    .we    (mem_we),
    .waddr (cur_addr),
    .wdata (mem_wdata),
    .raddr (cur_addr),
    .rdata (mem_rdata)
  );

endmodule

// File: rtl/twi_fram_slave_chk.sv
module twi_fram_slave_chk #(
  parameter int AW = 13
) (
  input logic          clk,
  input logic          rst,
  input logic          scl_hi,
  input logic          scl_rise,
  input logic          stop_det,
  input logic          mem_we,
  input logic [AW-1:0] cur_addr,
  input logic          wp,
  input logic          sda_oe
);

  assert_oe_steady_hi_R10: assert property (@(posedge clk) disable iff (rst)
    (scl_hi && $past(scl_hi)) |-> $stable(sda_oe));

  assert_stop_releases_R1: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !sda_oe);

  assert_write_on_rise_R4: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> scl_rise);

  assert_no_prot_write_R6: assert property (@(posedge clk) disable iff (rst)
    (mem_we && wp) |-> (cur_addr[AW-1:AW-2] != 2'b11));

  assert_addr_step_R5: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> (cur_addr == $past(cur_addr) + AW'(1)));

endmodule

bind twi_fram_slave twi_fram_slave_chk #(.AW(AW)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .scl_hi   (scl_s),
  .scl_rise (scl_rise),
  .stop_det (stop_det),
  .mem_we   (mem_we),
  .cur_addr (cur_addr),
  .wp       (wp_i),
  .sda_oe   (sda_oe)
);

// File: tb/twi_fram_slave_tb_top.sv
module twi_fram_slave_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic [2:0] sel = 3'b101;
  logic       wp = 1'b0;
  logic       sda_oe;
  wire        sda_line = sda_m & ~sda_oe;

  always #4 clk = ~clk;

  twi_fram_slave dut_i (
    .clk    (clk),
    .rst    (rst),
    .scl_i  (scl_m),
    .sda_i  (sda_line),
    .sda_oe (sda_oe),
    .sel_i  (sel),
    .wp_i   (wp)
  );

  // behavioural model state
  logic [7:0] mem_m [int];
  int         addr_m = 0;
  string      cur_req = "R9";
  bit         chk_en = 0;
  bit         exp_oe = 0;
  bit         done = 0;
  int         n_cmp = 0;
  int         n_bad = 0;

  // per-cycle comparison of the predicted line drive
  always @(negedge clk) begin
    if (chk_en && !done) begin
      n_cmp++;
      if (sda_oe !== exp_oe) begin
        n_bad++;
        $display("FAIL %s: sda_oe=%0b expected %0b at %0t", cur_req, sda_oe, exp_oe, $time);
      end
    end
  end

  task automatic check_val(input string req, input int got, input int expv);
    n_cmp++;
    if (got != expv) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h at %0t", req, got, expv, $time);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // one clock of the bus; entered with the clock low
  task automatic bit_slot(input bit mbit, input bit slave_drv, input bit chk, output bit seen);
    bit oe_a;
    chk_en = 0;
    tick(6);
    sda_m  = mbit;
    exp_oe = slave_drv;
    chk_en = chk;
    tick(2);
    scl_m = 1'b1;
    oe_a  = sda_oe;
    tick(4);
    seen = sda_line;
    tick(4);
    check_val("R10", sda_oe, oe_a);
    chk_en = 0;
    scl_m  = 1'b0;
  endtask

  task automatic do_start();
    chk_en = 0;
    sda_m  = 1'b1;
    tick(8);
    scl_m = 1'b1;
    tick(8);
    sda_m = 1'b0;
    tick(8);
    scl_m = 1'b0;
  endtask

  task automatic do_stop();
    chk_en = 0;
    sda_m  = 1'b0;
    tick(6);
    exp_oe = 0;
    chk_en = 1;
    tick(2);
    scl_m = 1'b1;
    tick(8);
    sda_m = 1'b1;
    tick(8);
    check_val("R1", sda_oe, 0);
    chk_en = 0;
  endtask

  task automatic send_byte(input logic [7:0] b, input bit exp_ack);
    bit seen;
    for (int i = 7; i >= 0; i--) bit_slot(b[i], 1'b0, 1'b1, seen);
    bit_slot(1'b1, exp_ack, 1'b1, seen);
    check_val(cur_req, seen, exp_ack ? 0 : 1);
  endtask

  task automatic recv_byte(input bit master_ack);
    bit         seen;
    logic [7:0] got;
    logic [7:0] expv;
    bit         known;
    known = mem_m.exists(addr_m);
    expv  = known ? mem_m[addr_m] : 8'h00;
    for (int i = 7; i >= 0; i--) begin
      bit_slot(1'b1, ~expv[i], known, seen);
      got[i] = seen;
    end
    if (known) check_val(cur_req, got, expv);
    addr_m = (addr_m + 1) & 16'h1FFF;
    bit_slot(master_ack ? 1'b0 : 1'b1, 1'b0, 1'b1, seen);
  endtask

  task automatic send_header(input logic [2:0] s, input logic [15:0] a16);
    do_start();
    send_byte({4'b1010, s, 1'b0}, 1'b1);
    send_byte(a16[15:8], 1'b1);
    send_byte(a16[7:0], 1'b1);
    addr_m = a16 & 16'h1FFF;
  endtask

  task automatic wr(input logic [15:0] a16, input logic [7:0] d[$]);
    send_header(sel, a16);
    foreach (d[k]) begin
      bit prot;
      prot = wp && (addr_m >= 16'h1800);
      send_byte(d[k], !prot);
      if (prot) break;
      mem_m[addr_m] = d[k];
      addr_m = (addr_m + 1) & 16'h1FFF;
    end
    do_stop();
  endtask

  task automatic rd_sel(input logic [15:0] a16, input int n);
    send_header(sel, a16);
    do_start();
    send_byte({4'b1010, sel, 1'b1}, 1'b1);
    for (int k = 0; k < n; k++) recv_byte(k < n - 1);
    do_stop();
  endtask

  task automatic rd_cur(input int n);
    do_start();
    send_byte({4'b1010, sel, 1'b1}, 1'b1);
    for (int k = 0; k < n; k++) recv_byte(k < n - 1);
    do_stop();
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: run did not complete, got timeout expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    bit seen;
    tick(5);
    rst = 1'b0;
    tick(4);
    // R9: line released out of reset
    cur_req = "R9";
    check_val("R9", sda_oe, 0);

    // R3: upper bits of high address byte ignored (E1h -> 01h)
    cur_req = "R3";
    wr(16'hE123, '{8'h5A});
    // R8: selective read through repeated START
    cur_req = "R8";
    rd_sel(16'h0123, 1);

    // R5/R7: burst write then sequential read
    cur_req = "R5";
    wr(16'h0200, '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66});
    cur_req = "R7";
    rd_sel(16'h0200, 4);
    // R9: address persists, current-address read continues at 0204h
    cur_req = "R9";
    rd_cur(2);

    // R5: wrap from 1FFFh to 0000h
    cur_req = "R5";
    wr(16'h1FFF, '{8'hA1, 8'hA2});
    rd_sel(16'h1FFF, 2);

    // R6: protected quarter
    cur_req = "R6";
    wr(16'h1800, '{8'h3C});
    wp = 1'b1;
    wr(16'h17FF, '{8'h44, 8'h99});
    rd_cur(1);            // address held at 1800h, value unchanged
    rd_sel(16'h17FF, 2);
    wp = 1'b0;

    // R2: wrong select straps, whole frame ignored
    cur_req = "R2";
    do_start();
    send_byte({4'b1010, sel ^ 3'b001, 1'b0}, 1'b0);
    send_byte(8'h01, 1'b0);
    send_byte(8'h23, 1'b0);
    send_byte(8'hFF, 1'b0);
    do_stop();
    // R2: wrong device type
    do_start();
    send_byte({4'b1011, sel, 1'b0}, 1'b0);
    send_byte(8'h01, 1'b0);
    do_stop();
    rd_sel(16'h0123, 1);

    // R4: STOP before 8th data bit leaves memory alone
    cur_req = "R4";
    send_header(sel, 16'h0202);
    for (int i = 7; i >= 3; i--) bit_slot(1'b0, 1'b0, 1'b1, seen);
    do_stop();
    rd_cur(1);
    // R1/R4: START before 8th bit aborts the write, address kept
    cur_req = "R1";
    send_header(sel, 16'h0203);
    for (int i = 7; i >= 2; i--) bit_slot(1'b1, 1'b0, 1'b1, seen);
    rd_cur(2);

    // R7: after master NACK the slave stays off the line
    cur_req = "R7";
    rd_sel(16'h0200, 1);
    do_start();
    send_byte({4'b1010, sel, 1'b1}, 1'b1);
    recv_byte(1'b0);
    for (int i = 0; i < 9; i++) bit_slot(1'b1, 1'b0, 1'b1, seen);
    do_stop();

    // R9: reset clears the held address, array contents kept
    cur_req = "R9";
    wr(16'h0000, '{8'hC3});
    wr(16'h0300, '{8'h7E});
    rst = 1'b1;
    tick(3);
    rst = 1'b0;
    tick(3);
    check_val("R9", sda_oe, 0);
    addr_m = 0;
    rd_cur(1);

    done = 1;
    summary();
    $finish;
  end

endmodule